// File: doc/BRIEF.md
# Programmable AND-OR Array Slice

This block is one slice of a programmable logic array. A bus of input signals enters an AND plane. There, every product term may pick any input in true form, in complemented form, or both. A second, fully programmable OR plane combines any product terms into any of the per-macrocell logic outputs. Two small groups of product terms have extra roles. The top group can be exported as local control signals, for use as asynchronous clocks, resets, presets or output enables by the macrocells downstream. A second group can be folded back: the inverted term, which is a NAND, re-enters the AND plane as an extra column and so builds wider logic. Either role can be switched off per term, and the term then returns to the general pool.

All programming lives in one serial configuration chain. The chain is loaded on the block clock while the load enable is high. The logic outputs, the control outputs and the folded-back terms are registered. A foldback term reaches the AND plane one clock after the term is formed, so no combinational loop exists.

Top module: `pla_slice`

## Requirements
- R1: Synchronous reset clears the whole configuration chain, the output registers and the foldback registers. On the first edge after reset is released, logic_out and ctrl_out are all zero.
- R2: On every edge where cfg_en is high, one bit of cfg_din is shifted into the chain, and logic_out, ctrl_out and the foldback registers are cleared.
- R3: A product term is the AND of the literals its mask selects. An empty mask gives 1. Mask columns 0..39 are the true inputs, 40..79 the complemented inputs, and 80..87 the foldback terms 0..7.
- R4: Logic output o is the OR of the available product terms its OR mask selects. An empty OR mask gives 0.
- R5: Outputs are registered. Inputs present before edge k show on logic_out and ctrl_out after edge k.
- R6: Product terms 40..47 are the control terms, and control i is term 40+i. When its enable is set, ctrl_out[i] carries the term and the OR plane does not see it.
- R7: When a control enable is clear, ctrl_out[i] stays 0 and the term is an ordinary OR-plane input.
- R8: Product terms 32..39 are the foldback terms, and foldback j is term 32+j. When its enable is set, foldback column j holds the inverse of the term one cycle later, and the OR plane does not see the term.
- R9: When a foldback enable is clear, foldback column j reads 0 and the term is an ordinary OR-plane input.
- R10: The chain holds 5008 bits, and the first bit shifted in ends in bit 5007. Product term p has its mask at bits p*88..p*88+87. The OR bit for output o and term p is at 4224+o*48+p. The control enables sit at 4992..4999 and the foldback enables at 5000..5007. The chain does not change while cfg_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also clocks the configuration chain |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| in_sig | input | 40 | Array inputs |
| logic_out | output | 16 | Registered per-macrocell sums |
| ctrl_out | output | 8 | Registered local control signals |

## Verification
The bench loads several configurations through the full chain and compares the outputs with a behavioural model on every clock. It exercises empty terms and empty sums, a term that selects both polarities of one input, and a term that needs all 40 inputs high. A design that misorders the chain bits, or that treats an empty mask as 0, shows wrong sums at once. Control terms and foldback terms are each tried enabled and disabled while selected in the OR plane. A design that leaks a claimed term into a sum, or that drops a released one, disagrees with the model. The foldback path is driven by changing inputs, so a missing or doubled register delay on the NAND feedback shows up as a one-cycle skew.

// File: rtl/pla_pkg.sv
package pla_pkg;
  // Width of one AND-plane row: true inputs, complemented inputs, foldback columns.
  function automatic int row_width(input int n_in, input int n_fb);
    return 2 * n_in + n_fb;
  endfunction

  // Total configuration chain length.
  function automatic int chain_bits(input int n_in, input int n_pt, input int n_out,
                                    input int n_ct, input int n_fb);
    return n_pt * row_width(n_in, n_fb) + n_out * n_pt + n_ct + n_fb;
  endfunction
endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int BITS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_en,
  input  logic            din,
  output logic [BITS-1:0] cfg_q
);
  always_ff @(posedge clk) begin
    if (rst)
      cfg_q <= '0;
    else if (shift_en)
      cfg_q <= {cfg_q[BITS-2:0], din};
  end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN = 40,
  parameter int N_PT = 48,
  parameter int N_FB = 8
) (
  input  logic [N_IN-1:0]                                   in_sig,
  input  logic [N_FB-1:0]                                   fb_col,
  input  logic [N_PT*pla_pkg::row_width(N_IN, N_FB)-1:0]   and_mask,
  output logic [N_PT-1:0]                                   pt
);
  localparam int W = pla_pkg::row_width(N_IN, N_FB);

  logic [W-1:0] col;
  assign col = {fb_col, ~in_sig, in_sig};

  for (genvar p = 0; p < N_PT; p++) begin : g_term
    // Unselected columns are forced high, so an empty row yields 1.
    assign pt[p] = &(~and_mask[p*W +: W] | col);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_PT  = 48,
  parameter int N_OUT = 16
) (
  input  logic [N_PT-1:0]       pt_avail,
  input  logic [N_OUT*N_PT-1:0] or_mask,
  output logic [N_OUT-1:0]      sum
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    assign sum[o] = |(or_mask[o*N_PT +: N_PT] & pt_avail);
  end
endmodule

// File: rtl/pla_slice.sv
module pla_slice #(
  parameter int N_IN  = 40,
  parameter int N_PT  = 48,
  parameter int N_OUT = 16,
  parameter int N_CT  = 8,
  parameter int N_FB  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_din,
  input  logic [N_IN-1:0]  in_sig,
  output logic [N_OUT-1:0] logic_out,
  output logic [N_CT-1:0]  ctrl_out
);
  localparam int W        = pla_pkg::row_width(N_IN, N_FB);
  localparam int AND_BITS = N_PT * W;
  localparam int OR_BASE  = AND_BITS;
  localparam int CT_BASE  = OR_BASE + N_OUT * N_PT;
  localparam int FB_BASE  = CT_BASE + N_CT;
  localparam int TOTAL    = pla_pkg::chain_bits(N_IN, N_PT, N_OUT, N_CT, N_FB);
  localparam int CT_LO    = N_PT - N_CT;
  localparam int FB_LO    = N_PT - N_CT - N_FB;

  logic [TOTAL-1:0] cfg_q;
  logic [N_CT-1:0]  ct_en;
  logic [N_FB-1:0]  fb_en;
  logic [N_FB-1:0]  fb_q;
  logic [N_PT-1:0]  pt;
  logic [N_PT-1:0]  claimed;
  logic [N_PT-1:0]  pt_avail;
  logic [N_OUT-1:0] sum;

  pla_cfg_chain #(.BITS(TOTAL)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cfg_en),
    .din      (cfg_din),
    .cfg_q    (cfg_q)
  );

  assign ct_en = cfg_q[CT_BASE +: N_CT];
  assign fb_en = cfg_q[FB_BASE +: N_FB];

  pla_and_plane #(.N_IN(N_IN), .N_PT(N_PT), .N_FB(N_FB)) u_and (
    .in_sig   (in_sig),
    .fb_col   (fb_q),
    .and_mask (cfg_q[AND_BITS-1:0]),
    .pt       (pt)
  );

  // Terms claimed as control or foldback leave the OR pool.
  always_comb begin
    claimed = '0;
    claimed[CT_LO +: N_CT] = ct_en;
    claimed[FB_LO +: N_FB] = fb_en;
  end
  assign pt_avail = pt & ~claimed;

  pla_or_plane #(.N_PT(N_PT), .N_OUT(N_OUT)) u_or (
    .pt_avail (pt_avail),
    .or_mask  (cfg_q[OR_BASE +: N_OUT*N_PT]),
    .sum      (sum)
  );

  always_ff @(posedge clk) begin
    if (rst || cfg_en) begin
      logic_out <= '0;
      ctrl_out  <= '0;
      fb_q      <= '0;
    end else begin
      logic_out <= sum;
      ctrl_out  <= pt[CT_LO +: N_CT] & ct_en;
      fb_q      <= ~pt[FB_LO +: N_FB] & fb_en;
    end
  end
endmodule

// File: rtl/pla_slice_chk.sv
module pla_slice_chk #(
  parameter int N_OUT = 16,
  parameter int N_CT  = 8,
  parameter int N_FB  = 8,
  parameter int TOTAL = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_en,
  input logic [N_OUT-1:0] logic_out,
  input logic [N_CT-1:0]  ctrl_out,
  input logic [N_CT-1:0]  ct_en,
  input logic [N_FB-1:0]  fb_en,
  input logic [N_FB-1:0]  fb_q,
  input logic [TOTAL-1:0] cfg_q
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (logic_out == '0 && ctrl_out == '0));

  assert_load_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_en) |-> (logic_out == '0 && ctrl_out == '0 && fb_q == '0));

  assert_chain_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg_q));

  assert_ctrl_gated_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_out & ~$past(ct_en)) == '0);

  assert_fold_gated_R9: assert property (@(posedge clk) disable iff (rst)
    (fb_q & ~$past(fb_en)) == '0);
endmodule

bind pla_slice pla_slice_chk #(
  .N_OUT (N_OUT),
  .N_CT  (N_CT),
  .N_FB  (N_FB),
  .TOTAL (TOTAL)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_en    (cfg_en),
  .logic_out (logic_out),
  .ctrl_out  (ctrl_out),
  .ct_en     (ct_en),
  .fb_en     (fb_en),
  .fb_q      (fb_q),
  .cfg_q     (cfg_q)
);

// File: tb/sim_pla_slice.sv
module sim_pla_slice;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN  = 40;
  localparam int N_PT  = 48;
  localparam int N_OUT = 16;
  localparam int N_CT  = 8;
  localparam int N_FB  = 8;
  localparam int W       = 2 * N_IN + N_FB;
  localparam int OR_BASE = N_PT * W;
  localparam int CT_BASE = OR_BASE + N_OUT * N_PT;
  localparam int FB_BASE = CT_BASE + N_CT;
  localparam int TOTAL   = FB_BASE + N_FB;
  localparam int CT_LO   = 40;
  localparam int FB_LO   = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b0;
  logic cfg_din = 1'b0;
  logic [N_IN-1:0]  in_sig = '0;
  logic [N_OUT-1:0] logic_out;
  logic [N_CT-1:0]  ctrl_out;

  pla_slice u0 (
    .clk (clk), .rst (rst), .cfg_en (cfg_en), .cfg_din (cfg_din),
    .in_sig (in_sig), .logic_out (logic_out), .ctrl_out (ctrl_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // Behavioural reference model
  logic [TOTAL-1:0] m_cfg;
  logic [N_FB-1:0]  m_fb;
  logic [N_OUT-1:0] exp_logic;
  logic [N_CT-1:0]  exp_ctrl;
  logic [N_PT-1:0]  ptv;
  logic             lit, acc, use_t;

  always @(posedge clk) begin
    if (rst) begin
      m_cfg = '0; m_fb = '0; exp_logic = '0; exp_ctrl = '0;
    end else if (cfg_en) begin
      m_cfg = {m_cfg[TOTAL-2:0], cfg_din};
      m_fb = '0; exp_logic = '0; exp_ctrl = '0;
    end else begin
      for (int p = 0; p < N_PT; p++) begin
        ptv[p] = 1'b1;
        for (int c = 0; c < W; c++) begin
          if (m_cfg[p*W + c]) begin
            if (c < N_IN) lit = in_sig[c];
            else if (c < 2*N_IN) lit = !in_sig[c - N_IN];
            else lit = m_fb[c - 2*N_IN];
            ptv[p] = ptv[p] & lit;
          end
        end
      end
      for (int o = 0; o < N_OUT; o++) begin
        acc = 1'b0;
        for (int p = 0; p < N_PT; p++) begin
          use_t = ptv[p];
          if (p >= CT_LO && m_cfg[CT_BASE + p - CT_LO]) use_t = 1'b0;
          if (p >= FB_LO && p < FB_LO + N_FB && m_cfg[FB_BASE + p - FB_LO]) use_t = 1'b0;
          if (m_cfg[OR_BASE + o*N_PT + p]) acc = acc | use_t;
        end
        exp_logic[o] = acc;
      end
      for (int i = 0; i < N_CT; i++)
        exp_ctrl[i] = ptv[CT_LO + i] & m_cfg[CT_BASE + i];
      for (int j = 0; j < N_FB; j++)
        m_fb[j] = m_cfg[FB_BASE + j] ? !ptv[FB_LO + j] : 1'b0;
    end
  end

  task automatic compare();
    checks++;
    if (logic_out !== exp_logic || ctrl_out !== exp_ctrl) begin
      fails++;
      $display("FAIL %s: logic_out=%h ctrl_out=%h expected logic_out=%h ctrl_out=%h",
               cur_req, logic_out, ctrl_out, exp_logic, exp_ctrl);
    end
  endtask

  task automatic cycle(input logic [N_IN-1:0] v);
    @(negedge clk);
    compare();
    in_sig = v;
  endtask

  logic [TOTAL-1:0] cfgv;

  task automatic set_and(input int p, input int c);
    cfgv[p*W + c] = 1'b1;
  endtask

  task automatic set_or(input int o, input int p);
    cfgv[OR_BASE + o*N_PT + p] = 1'b1;
  endtask

  // R10: first bit shifted lands in the top chain bit; outputs quiet while loading (R2)
  task automatic load_cfg();
    string keep;
    keep = cur_req;
    cur_req = "R2/R10";
    for (int b = TOTAL - 1; b >= 0; b--) begin
      @(negedge clk);
      compare();
      cfg_en = 1'b1;
      cfg_din = cfgv[b];
    end
    @(negedge clk);
    compare();
    cfg_en = 1'b0;
    cur_req = keep;
  endtask

  task automatic run_random(input int n);
    for (int k = 0; k < n; k++) cycle({$urandom, $urandom});
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    in_sig = '1;
    cycle('0);
    cycle('1);
    // R4: empty configuration, every sum stays 0
    cur_req = "R4";
    run_random(8);

    // R3 R4 R5: basic terms and sums
    cfgv = '0;
    set_and(0, 0); set_and(0, N_IN + 1);           // in0 & ~in1
    set_and(2, 2); set_and(2, N_IN + 2);           // in2 & ~in2 = 0
    set_and(3, 3); set_and(3, 4); set_and(3, 5);
    for (int c = 0; c < N_IN; c++) set_and(6, c);  // all inputs high
    set_or(0, 0); set_or(1, 1); set_or(2, 0); set_or(2, 3);
    set_or(3, 2); set_or(8, 6);
    load_cfg();
    cur_req = "R3/R4/R5";
    run_random(20);
    cycle('1); cycle('0); cycle('1); cycle({{(N_IN-1){1'b1}}, 1'b0});
    cycle(40'h00_0000_0001); cycle(40'h00_0000_0038);

    // R6 R7: control terms
    cfgv = '0;
    set_and(CT_LO, 6);                     // term 40 = in6
    set_and(CT_LO + 1, N_IN + 7);          // term 41 = ~in7
    set_and(CT_LO + 2, 12);                // term 42 = in12, control on
    set_or(3, CT_LO); set_or(3, CT_LO + 1);
    set_or(9, CT_LO + 2);
    cfgv[CT_BASE + 0] = 1'b1;
    cfgv[CT_BASE + 2] = 1'b1;
    load_cfg();
    cur_req = "R6/R7";
    run_random(20);
    cycle('0); cycle('1);

    // R8 R9: foldback terms
    cfgv = '0;
    set_and(FB_LO, 8); set_and(FB_LO, 9);          // term 32 = in8 & in9, folded
    set_and(4, 2*N_IN + 0); set_and(4, 10);        // term 4 = fb0 & in10
    set_and(FB_LO + 1, 11);                        // term 33 = in11, fold off
    set_and(5, 2*N_IN + 1);                        // term 5 = fb1 (reads 0)
    set_and(7, 2*N_IN + 0);                        // term 7 = fb0 alone
    set_or(4, 4); set_or(5, FB_LO); set_or(6, FB_LO + 1);
    set_or(7, 5); set_or(10, 7);
    cfgv[FB_BASE + 0] = 1'b1;
    load_cfg();
    cur_req = "R8/R9";
    run_random(30);
    cycle(40'h00_0000_0700); cycle(40'h00_0000_0400); cycle(40'h00_0000_0700);
    cycle(40'h00_0000_0000); cycle(40'h00_0000_0F00);

    // R1 again: reset after programming clears everything
    cur_req = "R1";
    @(negedge clk);
    compare();
    rst = 1'b1;
    cycle('1);
    rst = 1'b0;
    run_random(6);
    @(negedge clk);
    compare();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule